// File: doc/BRIEF.md
# Sector Protection and Erase Guard

This block sits in front of the program and erase engine of a 1-megabyte flash array whose physical sectors are not all the same size. Every program, block-erase, chip-erase, protect or unprotect request passes through it. The block maps the request address onto the sector layout. It widens an erase to the aligned block it covers and works out every physical sector that block overlaps. It then answers with a grant or a reject one clock later.

The guard holds one protect bit for each of the 19 sectors and an internal write-enable latch. The latch arms exactly one modifying operation. A hardware lock input stops protect bits from being cleared while it is high, but sectors can still be protected during that time. The array timing itself is outside this block. A grant tells the engine it may go ahead.

Sector numbering runs from the lowest address. Sectors 0 to 14 are 64 KB each and cover 0x00000 to 0xEFFFF. Above them sit sector 15 (16 KB at 0xF0000), sector 16 (8 KB at 0xF4000), sector 17 (8 KB at 0xF6000) and the 32 KB boot sector 18 at 0xF8000.

Top module: `sect_guard`

## Requirements
- R1: An address selects the sector that contains it, using the layout above, and protect bit i (prot_bits[i]) belongs to sector i.
- R2: After reset all 19 protect bits read 1, the write-enable latch reads 0, and no response is presented.
- R3: A high wren_set sets the latch. A request made while the latch is clear is rejected. A granted request clears the latch, and a rejected request leaves it unchanged.
- R4: A program request (op 0) is checked only against the sector holding its start address, since a 1 to 256 byte program wraps within its 256-byte page. It is granted when that sector is unprotected.
- R5: A block erase (op 1 = 4 KB, op 2 = 32 KB, op 3 = 64 KB) is aligned down to its block size. It is granted only when every sector the aligned block overlaps is unprotected.
- R6: A chip erase (op 4) is granted only when all 19 protect bits are 0.
- R7: Protect (op 5) sets the bit of the addressed sector, and unprotect (op 6) clears it. While hw_lock is high, an unprotect is rejected and no protect bit can fall, but a protect is still granted.
- R8: A request sampled at a clock edge is answered at that same edge. rsp_valid is high for one cycle with exactly one of rsp_grant and rsp_reject. The unused op code 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (0 program, 1/2/3 erase 4K/32K/64K, 4 chip, 5 protect, 6 unprotect) |
| req_addr | input | 20 | Byte address of the request |
| wren_set | input | 1 | Sets the write-enable latch |
| hw_lock | input | 1 | Hardware lock: protect bits may not be cleared |
| rsp_valid | output | 1 | Answer present |
| rsp_grant | output | 1 | Request granted |
| rsp_reject | output | 1 | Request rejected |
| prot_bits | output | 19 | Current protect bit per sector |
| wel | output | 1 | Write-enable latch state |

## Verification
The assertions check four things on every cycle. A grant always follows a set latch and leaves it cleared. Every answer carries exactly one verdict. No protect bit falls while the lock is held, and a protect that was granted sticks. A granted program or erase never touched a protected sector. Only the bench scenarios show that the sector map itself is right. These include the erases in the top 64 KB that span the small sectors, the alignment of unaligned erase addresses, chip-erase gating, and the fact that a rejected request leaves both the latch and the protect bits as they were.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;
  localparam int ADDR_W   = 20;
  localparam int BIG_LG   = 16;
  localparam int NUM_BIG  = 15;
  localparam int TOP_A_LG = 14;
  localparam int TOP_B_LG = 13;
  localparam int TOP_C_LG = 13;
  localparam int BOOT_LG  = 15;
  localparam int NUM_SECT = NUM_BIG + 4;
  localparam int ERS_S_LG = 12;
  localparam int ERS_M_LG = 15;
  localparam int ERS_L_LG = 16;
  localparam int TOP_BASE = NUM_BIG << BIG_LG;
  localparam int MEM_LAST = (1 << ADDR_W) - 1;

  typedef enum logic [2:0] {
    OP_PROG   = 3'd0,
    OP_ERS4K  = 3'd1,
    OP_ERS32K = 3'd2,
    OP_ERS64K = 3'd3,
    OP_CHIP   = 3'd4,
    OP_PROT   = 3'd5,
    OP_UNPROT = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  function automatic int sect_lo(int idx);
    if (idx < NUM_BIG) return idx << BIG_LG;
    case (idx - NUM_BIG)
      0:       return TOP_BASE;
      1:       return TOP_BASE + (1 << TOP_A_LG);
      2:       return TOP_BASE + (1 << TOP_A_LG) + (1 << TOP_B_LG);
      default: return TOP_BASE + (1 << TOP_A_LG) + (1 << TOP_B_LG) + (1 << TOP_C_LG);
    endcase
  endfunction

  function automatic int sect_hi(int idx);
    if (idx == NUM_SECT - 1) return MEM_LAST;
    return sect_lo(idx + 1) - 1;
  endfunction
endpackage

// File: rtl/sect_guard_span.sv
module sect_guard_span
  import sect_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NUM_SECT
) (
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  output logic [NS-1:0] span_o
);
  logic [AW-1:0] low_mask;
  logic [AW-1:0] lo_addr;
  logic [AW-1:0] hi_addr;
  logic          whole;

  always_comb begin
    whole    = 1'b0;
    low_mask = '0;
    case (op_i)
      OP_ERS4K:  low_mask = AW'((1 << ERS_S_LG) - 1);
      OP_ERS32K: low_mask = AW'((1 << ERS_M_LG) - 1);
      OP_ERS64K: low_mask = AW'((1 << ERS_L_LG) - 1);
      OP_CHIP:   whole    = 1'b1;
      default:   low_mask = '0;
    endcase
    lo_addr = addr_i & ~low_mask;
    hi_addr = addr_i | low_mask;
  end

  for (genvar g = 0; g < NS; g++) begin : g_sect
    localparam logic [AW-1:0] LO = AW'(sect_lo(g));
    localparam logic [AW-1:0] HI = AW'(sect_hi(g));
    logic above_lo;
    logic below_hi;
    if (g == 0) begin : g_first
      assign above_lo = 1'b1;
    end else begin : g_rest_lo
      assign above_lo = (hi_addr >= LO);
    end
    if (g == NS - 1) begin : g_last
      assign below_hi = 1'b1;
    end else begin : g_rest_hi
      assign below_hi = (lo_addr <= HI);
    end
    assign span_o[g] = whole | (above_lo & below_hi);
  end

  // R1: a single address always lands in exactly one sector
  always_comb begin
    if (!$isunknown({op_i, addr_i}) &&
        (op_i == OP_PROG || op_i == OP_PROT || op_i == OP_UNPROT)) begin
      a_r1_one_sector: assert ($onehot(span_o));
    end
  end
endmodule

// File: rtl/sect_guard_bits.sv
module sect_guard_bits #(
  parameter int NS = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic          lock_i,
  output logic [NS-1:0] prot_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_o <= '1;
      armed  <= 1'b0;
    end else begin
      prot_o <= (prot_o | set_i) & ~(clr_i & {NS{~lock_i}});
      armed  <= 1'b1;
    end
  end

  a_r7_lock_freeze: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lock_i) |-> ((~prot_o & $past(prot_o)) == '0));

  a_r7_set_sticks: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(set_i) != '0) |-> (($past(set_i) & ~prot_o) == '0));
endmodule

// File: rtl/sect_guard_wel.sv
module sect_guard_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic use_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (rst)        wel_o <= 1'b0;
    else if (use_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sect_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NS = NUM_SECT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          wren_set,
  input  logic          hw_lock,
  output logic          rsp_valid,
  output logic          rsp_grant,
  output logic          rsp_reject,
  output logic [NS-1:0] prot_bits,
  output logic          wel
);
  op_e           op;
  logic [NS-1:0] span;
  logic [NS-1:0] hit;
  logic          allowed;
  logic          grant_d;
  logic          touches_array;
  logic [NS-1:0] set_mask;
  logic [NS-1:0] clr_mask;
  logic          armed;

  assign op = op_e'(req_op);

  sect_guard_span #(.AW(AW), .NS(NS)) u_span (
    .op_i   (op),
    .addr_i (req_addr),
    .span_o (span)
  );

  assign hit = span & prot_bits;

  always_comb begin
    allowed       = 1'b0;
    touches_array = 1'b0;
    case (op)
      OP_PROG, OP_ERS4K, OP_ERS32K, OP_ERS64K, OP_CHIP: begin
        allowed       = wel && (hit == '0);
        touches_array = 1'b1;
      end
      OP_PROT:   allowed = wel;
      OP_UNPROT: allowed = wel && !hw_lock;
      default:   allowed = 1'b0;
    endcase
  end

  assign grant_d  = req_valid && allowed;
  assign set_mask = (grant_d && op == OP_PROT)   ? span : '0;
  assign clr_mask = (grant_d && op == OP_UNPROT) ? span : '0;

  sect_guard_bits #(.NS(NS)) u_bits (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .lock_i (hw_lock),
    .prot_o (prot_bits)
  );

  sect_guard_wel u_wel (
    .clk   (clk),
    .rst   (rst),
    .set_i (wren_set),
    .use_i (grant_d),
    .wel_o (wel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_reject <= 1'b0;
      armed      <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_grant  <= grant_d;
      rsp_reject <= req_valid && !allowed;
      armed      <= 1'b1;
    end
  end

  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_grant |-> $past(wel));

  a_r3_grant_clears_wel: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_grant |-> !wel);

  a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_valid |-> $onehot({rsp_grant, rsp_reject}));

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (rst || !armed)
    !rsp_valid |-> !(rsp_grant || rsp_reject));

  a_r5_no_protected_hit: assert property (@(posedge clk) disable iff (rst || !armed)
    (rsp_grant && $past(touches_array)) |-> (($past(span) & $past(prot_bits)) == '0));
endmodule

// File: tb/sect_guard_bench.sv
module sect_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic        wren_set = 1'b0;
  logic        hw_lock = 1'b0;
  logic        rsp_valid, rsp_grant, rsp_reject, wel;
  logic [18:0] prot_bits;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [18:0] exp_prot;

  always #2.5 clk = ~clk;

  sect_guard u_sect_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .wren_set(wren_set), .hw_lock(hw_lock),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reject(rsp_reject),
    .prot_bits(prot_bits), .wel(wel)
  );

  function automatic logic [19:0] start_of(int i);
    if (i < 15) return 20'(i * 32'h10000);
    case (i)
      15: return 20'hF0000;
      16: return 20'hF4000;
      17: return 20'hF6000;
      default: return 20'hF8000;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [19:0] addr, bit exp_grant, string req);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_grant", 32'(rsp_grant), 32'(exp_grant));
    chk(req, "rsp_reject", 32'(rsp_reject), 32'(!exp_grant));
  endtask

  task automatic arm();
    @(negedge clk); wren_set = 1'b1;
    @(posedge clk); #1; wren_set = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2", "prot_bits", 32'(prot_bits), 32'h7FFFF);
    chk("R2", "wel", 32'(wel), 32'd0);
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'd0);
    exp_prot = 19'h7FFFF;
  endtask

  task automatic t_no_latch();
    issue(3'd0, 20'h30000, 0, "R3");
    issue(3'd6, 20'h30000, 0, "R3");
    chk("R3", "prot unchanged", 32'(prot_bits), 32'(exp_prot));
  endtask

  task automatic t_unprotect_program();
    arm();
    chk("R3", "wel set", 32'(wel), 32'd1);
    issue(3'd6, 20'h3ABCD, 1, "R7");
    exp_prot[3] = 1'b0;
    chk("R1", "sector 3 cleared", 32'(prot_bits), 32'(exp_prot));
    chk("R3", "wel cleared", 32'(wel), 32'd0);
    arm();
    issue(3'd0, 20'h3FFFF, 1, "R4");
    arm();
    issue(3'd0, 20'h40000, 0, "R4");
    chk("R3", "reject keeps wel", 32'(wel), 32'd1);
  endtask

  task automatic t_top_erase();
    for (int i = 15; i < 18; i++) begin
      arm();
      issue(3'd6, start_of(i), 1, "R7");
      exp_prot[i] = 1'b0;
    end
    chk("R1", "small sectors clear", 32'(prot_bits), 32'(exp_prot));
    arm(); issue(3'd2, 20'hF1234, 1, "R5");
    arm(); issue(3'd3, 20'hF0000, 0, "R5");
    arm(); issue(3'd1, 20'hF5FFF, 1, "R5");
    arm(); issue(3'd2, 20'hFC000, 0, "R5");
    arm(); issue(3'd1, 20'hF8000, 0, "R5");
    arm(); issue(3'd6, 20'hFFFFF, 1, "R1");
    exp_prot[18] = 1'b0;
    chk("R1", "boot sector clear", 32'(prot_bits), 32'(exp_prot));
    arm(); issue(3'd3, 20'hFABCD, 1, "R5");
    arm(); issue(3'd3, 20'h3FFFF, 1, "R5");
    arm(); issue(3'd3, 20'h4FFFF, 0, "R5");
  endtask

  task automatic t_lock();
    hw_lock = 1'b1;
    arm();
    issue(3'd6, 20'h00000, 0, "R7");
    chk("R7", "locked bit stays", 32'(prot_bits), 32'(exp_prot));
    chk("R3", "wel after lock reject", 32'(wel), 32'd1);
    issue(3'd5, 20'h31000, 1, "R7");
    exp_prot[3] = 1'b1;
    chk("R7", "protect under lock", 32'(prot_bits), 32'(exp_prot));
    @(negedge clk); hw_lock = 1'b0;
  endtask

  task automatic t_chip();
    arm();
    issue(3'd4, 20'h12345, 0, "R6");
    for (int i = 0; i < 19; i++) begin
      arm();
      issue(3'd6, start_of(i) + 20'h00010, 1, "R7");
    end
    exp_prot = '0;
    chk("R6", "all clear", 32'(prot_bits), 32'(exp_prot));
    arm();
    issue(3'd4, 20'h00000, 1, "R6");
    arm();
    issue(3'd5, 20'h80000, 1, "R7");
    exp_prot[8] = 1'b1;
    chk("R1", "sector 8 set", 32'(prot_bits), 32'(exp_prot));
    arm();
    issue(3'd4, 20'h00000, 0, "R6");
  endtask

  task automatic t_reserved();
    arm();
    issue(3'd7, 20'h10000, 0, "R8");
    chk("R8", "wel kept", 32'(wel), 32'd1);
    @(posedge clk); #1;
    chk("R8", "single cycle valid", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_no_latch();
    t_unprotect_program();
    t_top_erase();
    t_lock();
    t_chip();
    t_reserved();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule